// File: doc/BRIEF.md
# Multi-cycle Processor Control Sequencer

This block is the control unit that steps a multi-cycle processor datapath through each instruction. Every instruction first spends one cycle in a fetch state and one in a decode state. The decode state then picks one of five execution paths from the 6-bit opcode: load, store, register-register, branch-on-equal or jump. Each path takes one to three further states and then returns to fetch. An opcode that matches no class sends the sequencer straight back to fetch.

The controller is a Moore machine. Every control strobe, and the 4-bit state number that is exported alongside them, is a function of the current state only. The opcode is used only to choose the next state, and only in the decode state and the address state. The five class opcodes are parameters. A synchronous reset puts the machine into the fetch state.

Top module: `mc_ctrl_fsm`

## Requirements
- R1: While `rst` is high at a rising clock edge, the state becomes 0 (fetch). This holds whichever state the machine is in at that edge.
- R2: State 0 drives `memRdEn`=1, `instLatch`=1, `pcLoad`=1, `addrSel`=0, `aluASel`=0, `aluBSel`=01, `aluFunc`=00 and `pcNextSel`=00, with every other strobe at 0. Its next state is always 1.
- R3: State 1 drives `aluASel`=0, `aluBSel`=11 and `aluFunc`=00, with all other strobes at 0. Its next state depends on the opcode: 100011 and 101011 go to 2, 000000 goes to 6, 000100 goes to 8 and 000010 goes to 9.
- R4: State 2 drives `aluASel`=1, `aluBSel`=10 and `aluFunc`=00, with the rest at 0. It moves to state 3 when the opcode is 100011 and to state 5 otherwise.
- R5: State 3 drives `memRdEn`=1 and `addrSel`=1, with the rest at 0, and then moves to state 4.
- R6: State 4 drives `rfWrEn`=1, `rfDstSel`=0 and `rfSrcSel`=1, with the rest at 0, and then moves to state 0.
- R7: State 5 drives `memWrEn`=1 and `addrSel`=1, with the rest at 0, and then moves to state 0.
- R8: State 6 drives `aluASel`=1, `aluBSel`=00 and `aluFunc`=10, with the rest at 0, and then moves to state 7. State 7 drives `rfWrEn`=1, `rfDstSel`=1 and `rfSrcSel`=0, with the rest at 0, and then moves to state 0.
- R9: State 8 drives `aluASel`=1, `aluBSel`=00, `aluFunc`=01, `pcLoadIfEq`=1 and `pcNextSel`=01, with the rest at 0, and then moves to state 0.
- R10: State 9 drives `pcLoad`=1 and `pcNextSel`=10, with the rest at 0, and then moves to state 0.
- R11: The number of cycles from one fetch to the next is 5 for load, 4 for store, 4 for register-register, 3 for branch and 3 for jump.
- R12: In state 1, an opcode that matches none of the five class codes returns the machine to state 0, so that instruction takes 2 cycles.
- R13: The outputs depend only on the state. A change of opcode inside a state does not change any output during that state, and a read strobe and a write strobe to memory are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state changes happen on the rising edge |
| rst | input | 1 | Synchronous reset to the fetch state, active high |
| opcode | input | 6 | Opcode field of the instruction currently held |
| memRdEn | output | 1 | Memory read strobe |
| memWrEn | output | 1 | Memory write strobe |
| instLatch | output | 1 | Load the instruction holding register |
| pcLoad | output | 1 | Unconditional program-counter load |
| pcLoadIfEq | output | 1 | Program-counter load gated by the ALU zero flag |
| addrSel | output | 1 | Memory address source: 0 program counter, 1 ALU result register |
| rfWrEn | output | 1 | Register-file write strobe |
| rfDstSel | output | 1 | Destination register field: 0 second source field, 1 third field |
| rfSrcSel | output | 1 | Register write data: 0 ALU result register, 1 memory data register |
| aluASel | output | 1 | ALU first operand: 0 program counter, 1 first register operand |
| aluBSel | output | 2 | ALU second operand: 00 register, 01 constant 4, 10 extended immediate, 11 shifted immediate |
| aluFunc | output | 2 | ALU operation class: 00 add, 01 subtract, 10 by function field |
| pcNextSel | output | 2 | Program-counter source: 00 ALU output, 01 ALU result register, 10 jump target |
| ctrlState | output | 4 | Current state number, 0 to 9 |

## Verification
The bench builds the block with its default class opcodes. Because the opcode space has only 64 values, it can walk every opcode value through a complete instruction from fetch back to fetch. For each value it compares the state number and the whole control word in every cycle, and this covers all five paths as well as the fall-back for unknown codes. In every state other than decode and address, the bench replaces the opcode with its complement, so an output that depends on the opcode would show up at once. A reset asserted in the middle of a register-register instruction is also checked.

// File: rtl/mc_ctrl_pkg.sv
package mc_ctrl_pkg;

  localparam int OP_W    = 6;
  localparam int STATE_W = 4;

  typedef enum logic [STATE_W-1:0] {
    S_FETCH  = 4'd0,
    S_DECODE = 4'd1,
    S_ADDR   = 4'd2,
    S_LDRD   = 4'd3,
    S_LDWB   = 4'd4,
    S_STWR   = 4'd5,
    S_EXEC   = 4'd6,
    S_RWB    = 4'd7,
    S_BEQ    = 4'd8,
    S_JMP    = 4'd9
  } stateT;

  // Strobe bundle from the control word decoder to the top
  typedef struct packed {
    logic       memRdEn;
    logic       memWrEn;
    logic       instLatch;
    logic       pcLoad;
    logic       pcLoadIfEq;
    logic       addrSel;
    logic       rfWrEn;
    logic       rfDstSel;
    logic       rfSrcSel;
    logic       aluASel;
    logic [1:0] aluBSel;
    logic [1:0] aluFunc;
    logic [1:0] pcNextSel;
  } ctrlT;

endpackage

// File: rtl/mc_ctrl_next.sv
module mc_ctrl_next
  import mc_ctrl_pkg::*;
#(
  parameter logic [OP_W-1:0] LOAD_OP  = 6'b100011,
  parameter logic [OP_W-1:0] STORE_OP = 6'b101011,
  parameter logic [OP_W-1:0] RR_OP    = 6'b000000,
  parameter logic [OP_W-1:0] BEQ_OP   = 6'b000100,
  parameter logic [OP_W-1:0] JMP_OP   = 6'b000010
) (
  input  stateT             curState,
  input  logic [OP_W-1:0]   opcode,
  output stateT             nextState
);

  logic isLoad, isStore, isRr, isBeq, isJmp;

  always_comb begin
    isLoad  = (opcode == LOAD_OP);
    isStore = (opcode == STORE_OP);
    isRr    = (opcode == RR_OP);
    isBeq   = (opcode == BEQ_OP);
    isJmp   = (opcode == JMP_OP);
  end

  always_comb begin
    nextState = S_FETCH;
    case (curState)
      S_FETCH:  nextState = S_DECODE;
      S_DECODE: begin
        if (isLoad || isStore) nextState = S_ADDR;
        else if (isRr)         nextState = S_EXEC;
        else if (isBeq)        nextState = S_BEQ;
        else if (isJmp)        nextState = S_JMP;
        else                   nextState = S_FETCH;
      end
      S_ADDR:   nextState = isLoad ? S_LDRD : S_STWR;
      S_LDRD:   nextState = S_LDWB;
      S_EXEC:   nextState = S_RWB;
      default:  nextState = S_FETCH;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_decode.sv
module mc_ctrl_decode
  import mc_ctrl_pkg::*;
(
  input  stateT curState,
  output ctrlT  ctl
);

  always_comb begin
    ctl = '0;
    case (curState)
      S_FETCH: begin
        ctl.memRdEn   = 1'b1;
        ctl.instLatch = 1'b1;
        ctl.pcLoad    = 1'b1;
        ctl.aluBSel   = 2'b01;
      end
      S_DECODE: ctl.aluBSel = 2'b11;
      S_ADDR: begin
        ctl.aluASel = 1'b1;
        ctl.aluBSel = 2'b10;
      end
      S_LDRD: begin
        ctl.memRdEn = 1'b1;
        ctl.addrSel = 1'b1;
      end
      S_LDWB: begin
        ctl.rfWrEn   = 1'b1;
        ctl.rfSrcSel = 1'b1;
      end
      S_STWR: begin
        ctl.memWrEn = 1'b1;
        ctl.addrSel = 1'b1;
      end
      S_EXEC: begin
        ctl.aluASel = 1'b1;
        ctl.aluFunc = 2'b10;
      end
      S_RWB: begin
        ctl.rfWrEn   = 1'b1;
        ctl.rfDstSel = 1'b1;
      end
      S_BEQ: begin
        ctl.aluASel    = 1'b1;
        ctl.aluFunc    = 2'b01;
        ctl.pcLoadIfEq = 1'b1;
        ctl.pcNextSel  = 2'b01;
      end
      S_JMP: begin
        ctl.pcLoad    = 1'b1;
        ctl.pcNextSel = 2'b10;
      end
      default: ctl = '0;
    endcase
  end

endmodule

// File: rtl/mc_ctrl_fsm.sv
module mc_ctrl_fsm
  import mc_ctrl_pkg::*;
#(
  parameter logic [5:0] LOAD_OP  = 6'b100011,
  parameter logic [5:0] STORE_OP = 6'b101011,
  parameter logic [5:0] RR_OP    = 6'b000000,
  parameter logic [5:0] BEQ_OP   = 6'b000100,
  parameter logic [5:0] JMP_OP   = 6'b000010
) (
  input  logic       clk,
  input  logic       rst,
  input  logic [5:0] opcode,
  output logic       memRdEn,
  output logic       memWrEn,
  output logic       instLatch,
  output logic       pcLoad,
  output logic       pcLoadIfEq,
  output logic       addrSel,
  output logic       rfWrEn,
  output logic       rfDstSel,
  output logic       rfSrcSel,
  output logic       aluASel,
  output logic [1:0] aluBSel,
  output logic [1:0] aluFunc,
  output logic [1:0] pcNextSel,
  output logic [3:0] ctrlState
);

  stateT stateReg;
  stateT stateNxt;
  ctrlT  ctl;

  mc_ctrl_next #(
    .LOAD_OP (LOAD_OP),
    .STORE_OP(STORE_OP),
    .RR_OP   (RR_OP),
    .BEQ_OP  (BEQ_OP),
    .JMP_OP  (JMP_OP)
  ) u_next (
    .curState (stateReg),
    .opcode   (opcode),
    .nextState(stateNxt)
  );

  mc_ctrl_decode u_decode (
    .curState(stateReg),
    .ctl     (ctl)
  );

  always_ff @(posedge clk) begin
    if (rst) stateReg <= S_FETCH;
    else     stateReg <= stateNxt;
  end

  assign memRdEn    = ctl.memRdEn;
  assign memWrEn    = ctl.memWrEn;
  assign instLatch  = ctl.instLatch;
  assign pcLoad     = ctl.pcLoad;
  assign pcLoadIfEq = ctl.pcLoadIfEq;
  assign addrSel    = ctl.addrSel;
  assign rfWrEn     = ctl.rfWrEn;
  assign rfDstSel   = ctl.rfDstSel;
  assign rfSrcSel   = ctl.rfSrcSel;
  assign aluASel    = ctl.aluASel;
  assign aluBSel    = ctl.aluBSel;
  assign aluFunc    = ctl.aluFunc;
  assign pcNextSel  = ctl.pcNextSel;
  assign ctrlState  = stateReg;

endmodule

// File: rtl/mc_ctrl_fsm_chk.sv
module mc_ctrl_fsm_chk #(
  parameter logic [5:0] LoadOp  = 6'b100011,
  parameter logic [5:0] StoreOp = 6'b101011,
  parameter logic [5:0] RrOp    = 6'b000000,
  parameter logic [5:0] BeqOp   = 6'b000100,
  parameter logic [5:0] JmpOp   = 6'b000010
) (
  input logic       clk,
  input logic       rst,
  input logic [5:0] opcode,
  input logic       memRdEn,
  input logic       memWrEn,
  input logic [3:0] ctrlState
);

  logic knownOp;
  assign knownOp = (opcode == LoadOp) || (opcode == StoreOp) || (opcode == RrOp) ||
                   (opcode == BeqOp) || (opcode == JmpOp);

  a_r2_fetch_then_decode: assert property (@(posedge clk) disable iff (rst)
    ctrlState == 4'd0 |=> ctrlState == 4'd1);

  a_r3_beq_dispatch: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == 4'd1 && opcode == BeqOp) |=> ctrlState == 4'd8);

  a_r4_store_path: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == 4'd2 && opcode != LoadOp) |=> ctrlState == 4'd5);

  a_r5_read_then_wb: assert property (@(posedge clk) disable iff (rst)
    ctrlState == 4'd3 |=> ctrlState == 4'd4);

  a_r8_exec_then_wb: assert property (@(posedge clk) disable iff (rst)
    ctrlState == 4'd6 |=> ctrlState == 4'd7);

  a_r11_last_step_returns: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == 4'd4 || ctrlState == 4'd5 || ctrlState == 4'd7 ||
     ctrlState == 4'd8 || ctrlState == 4'd9) |=> ctrlState == 4'd0);

  a_r12_unknown_refetch: assert property (@(posedge clk) disable iff (rst)
    (ctrlState == 4'd1 && !knownOp) |=> ctrlState == 4'd0);

  a_r13_no_rd_wr_overlap: assert property (@(posedge clk) disable iff (rst)
    !(memRdEn && memWrEn));

endmodule

bind mc_ctrl_fsm mc_ctrl_fsm_chk #(
  .LoadOp (LOAD_OP),
  .StoreOp(STORE_OP),
  .RrOp   (RR_OP),
  .BeqOp  (BEQ_OP),
  .JmpOp  (JMP_OP)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .opcode   (opcode),
  .memRdEn  (memRdEn),
  .memWrEn  (memWrEn),
  .ctrlState(ctrlState)
);

// File: tb/tb_mc_ctrl_fsm.sv
module tb_mc_ctrl_fsm;

  logic       clk = 1'b0;
  logic       rst;
  logic [5:0] opcode;
  logic       memRdEn, memWrEn, instLatch, pcLoad, pcLoadIfEq, addrSel;
  logic       rfWrEn, rfDstSel, rfSrcSel, aluASel;
  logic [1:0] aluBSel, aluFunc, pcNextSel;
  logic [3:0] ctrlState;

  int nRun  = 0;
  int nFail = 0;

  always #4 clk = ~clk;   // 125 MHz

  mc_ctrl_fsm dut (
    .clk(clk), .rst(rst), .opcode(opcode),
    .memRdEn(memRdEn), .memWrEn(memWrEn), .instLatch(instLatch),
    .pcLoad(pcLoad), .pcLoadIfEq(pcLoadIfEq), .addrSel(addrSel),
    .rfWrEn(rfWrEn), .rfDstSel(rfDstSel), .rfSrcSel(rfSrcSel),
    .aluASel(aluASel), .aluBSel(aluBSel), .aluFunc(aluFunc),
    .pcNextSel(pcNextSel), .ctrlState(ctrlState)
  );

  // Packed observation order:
  // memRd memWr instLatch pcLoad pcLoadIfEq addrSel rfWr rfDst rfSrc aluA aluB[2] aluFunc[2] pcNext[2]
  function automatic logic [15:0] actWord();
    return {memRdEn, memWrEn, instLatch, pcLoad, pcLoadIfEq, addrSel,
            rfWrEn, rfDstSel, rfSrcSel, aluASel, aluBSel, aluFunc, pcNextSel};
  endfunction

  function automatic logic [15:0] expWord(int s);
    case (s)
      0: return 16'b1011_0000_0001_0000;   // R2
      1: return 16'b0000_0000_0011_0000;   // R3
      2: return 16'b0000_0000_0110_0000;   // R4
      3: return 16'b1000_0100_0000_0000;   // R5
      4: return 16'b0000_0010_1000_0000;   // R6
      5: return 16'b0100_0100_0000_0000;   // R7
      6: return 16'b0000_0000_0100_1000;   // R8 execute
      7: return 16'b0000_0011_0000_0000;   // R8 write-back
      8: return 16'b0000_1000_0100_0101;   // R9
      9: return 16'b0001_0000_0000_0010;   // R10
      default: return 16'h0;
    endcase
  endfunction

  function automatic string reqOf(int s);
    case (s)
      0: return "R2";
      1: return "R3";
      2: return "R4";
      3: return "R5";
      4: return "R6";
      5: return "R7";
      6, 7: return "R8";
      8: return "R9";
      default: return "R10";
    endcase
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    nRun++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  initial begin
    #(8 * 100000);
    nFail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    rst = 1'b1;
    opcode = 6'd0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk("R1 reset state", 32'(ctrlState), 32'd0);
    chk("R1 reset word", 32'(actWord()), 32'(expWord(0)));
    rst = 1'b0;

    // Exhaustive opcode sweep, one full instruction per value
    for (int op = 0; op < 64; op++) begin
      int path[5];
      int len;
      int cyc;
      case (op)
        35: begin path = '{0, 1, 2, 3, 4}; len = 5; end
        43: begin path = '{0, 1, 2, 5, 0}; len = 4; end
        0:  begin path = '{0, 1, 6, 7, 0}; len = 4; end
        4:  begin path = '{0, 1, 8, 0, 0}; len = 3; end
        2:  begin path = '{0, 1, 9, 0, 0}; len = 3; end
        default: begin path = '{0, 1, 0, 0, 0}; len = 2; end
      endcase
      cyc = 0;
      for (int i = 0; i < len; i++) begin
        logic junk;
        junk = !(path[i] == 1 || path[i] == 2);
        opcode = junk ? ~6'(op) : 6'(op);
        #1;
        chk(reqOf(path[i]), 32'(ctrlState), 32'(path[i]));
        chk(junk ? "R13 opcode-independent word" : reqOf(path[i]),
            32'(actWord()), 32'(expWord(path[i])));
        cyc++;
        @(negedge clk);
      end
      #1;
      chk(len == 2 ? "R12 unknown refetch" : "R11 back to fetch", 32'(ctrlState), 32'd0);
      chk("R11 cycle count", 32'(cyc), 32'(len));
    end

    // Reset in the middle of a register-register instruction
    opcode = 6'd0;
    @(negedge clk);
    @(negedge clk);
    chk("R8 reached execute", 32'(ctrlState), 32'd6);
    rst = 1'b1;
    @(negedge clk);
    chk("R1 mid-instruction reset", 32'(ctrlState), 32'd0);
    rst = 1'b0;
    @(negedge clk);
    chk("R2 after reset", 32'(ctrlState), 32'd1);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule